// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one complete management transaction on a two-wire PHY management bus. A single-cycle start strobe launches a frame. The frame direction, the 5-bit PHY address, the 5-bit register address and, for writes, 16 bits of data are all captured on that strobe. The engine makes the management clock from the system clock with a parameterised divider. It shifts the frame out with the data line's output enable under its own control. On reads it samples the PHY's answer and presents it as a 16-bit word.

Between frames the management clock rests low and the data line is released. While a frame is in progress the engine ignores further start strobes. A one-cycle completion pulse marks the end of the trailing idle bit. At that point a read result is valid on the read-data port.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset and between frames, `mdc` is low, `mdio_oe` is low, `done` is low and `rd_data` is zero until the first read completes.
- R2: The management clock period is 2*DIV_HALF system clocks, with the rising edge DIV_HALF clocks after the falling edge. A frame has PRE_LEN+33 such periods, and `done` goes high 2*DIV_HALF*(PRE_LEN+33) clocks after the edge that accepts `start`.
- R3: Seen on the line, each frame starts with PRE_LEN ones and then the start code 0,1. Next comes the opcode: 1,0 when `rd_sel`=1 (read) and 0,1 when `rd_sel`=0 (write). Then follow the PHY address and the register address, each sent most significant bit first. The engine drives all of these bits.
- R4: On a write, the engine drives the turnaround as 1 then 0, followed by `wr_data` MSB first, for 16 bits.
- R5: On a read, the engine releases the line (`mdio_oe`=0) from the first turnaround bit to the end of the data field. It samples `mdio_i` on the 16 data-bit rising edges, MSB first, and updates `rd_data` in the cycle `done` rises. A write frame leaves `rd_data` unchanged.
- R6: The final bit of every frame is an idle bit, and the line is released during it.
- R7: `mdio_o` and `mdio_oe` change only together with a falling `mdc`, or on frame start while `mdc` is low. They never change while `mdc` is high.
- R8: A `start` strobe that arrives while a frame is in progress is ignored. So are the input values that come with it. The running frame continues unchanged.
- R9: `done` is high for exactly one system clock per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run a frame |
| rd_sel | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |
| rd_data | output | 16 | Result of the last read frame |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the engine with DIV_HALF=2 and the full 32-bit preamble. This keeps one frame at 260 clocks, which is short enough to sweep every PHY address and every register address in both directions. It also covers sixteen walking-one write data words. A behavioural PHY with a pull-up answers reads with a word derived from both addresses. Each frame's 65 line bits and enables are therefore compared with a vector computed in the bench, in every position. One frame per direction receives a second start strobe with inverted inputs partway through, to confirm that the running frame is not disturbed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = 4 + 2 * ADDR_W;  // start + opcode + two addresses
  localparam int BODY_W  = 2 + DATA_W;      // turnaround + data

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             mdc_q, mdc_n;
  logic             tick;

  assign tick = en && (cnt_q == CNT_LAST);

  always_comb begin
    if (!en) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (tick) begin
      cnt_n = '0;
      mdc_n = ~mdc_q;
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
      mdc_n = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;

  assert_mdc_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mdc_q);
  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc_q) || $fell(mdc_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fall_tick,
  output logic              busy,
  output logic              rd_active,
  output logic [$clog2(PRE_LEN+HDR_W+BODY_W+2)-1:0] bit_idx,
  output logic              frame_end,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done
);
  localparam int FRAME_W  = PRE_LEN + HDR_W + BODY_W;
  localparam int TOTAL    = FRAME_W + 1;
  localparam int ADDR_END = PRE_LEN + HDR_W;
  localparam int IDX_W    = $clog2(TOTAL + 1);

  logic               busy_q, busy_n;
  logic               rd_q, rd_n;
  logic               done_q, done_n;
  logic               o_q, o_n;
  logic               oe_q, oe_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [FRAME_W-1:0] frame;

  assign frame = {{PRE_LEN{1'b1}}, SOF_CODE, rd_sel ? OP_RD : OP_WR,
                  phy_addr, reg_addr, TA_WR, rd_sel ? DATA_W'(0) : wr_data};

  function automatic logic drives(input logic [IDX_W-1:0] k, input logic is_rd);
    return (k < IDX_W'(ADDR_END)) || (!is_rd && (k < IDX_W'(FRAME_W)));
  endfunction

  always_comb begin
    busy_n    = busy_q;
    rd_n      = rd_q;
    done_n    = 1'b0;
    o_n       = o_q;
    oe_n      = oe_q;
    idx_n     = idx_q;
    sh_n      = sh_q;
    frame_end = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        rd_n   = rd_sel;
        idx_n  = '0;
        sh_n   = frame;
        o_n    = frame[FRAME_W-1];
        oe_n   = 1'b1;
      end
    end else if (fall_tick) begin
      if (idx_q == IDX_W'(TOTAL - 1)) begin
        busy_n    = 1'b0;
        done_n    = 1'b1;
        idx_n     = '0;
        o_n       = 1'b0;
        oe_n      = 1'b0;
        frame_end = 1'b1;
      end else begin
        idx_n = idx_q + IDX_W'(1);
        sh_n  = sh_q << 1;
        o_n   = sh_q[FRAME_W-2];
        oe_n  = drives(idx_n, rd_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      o_q    <= 1'b0;
      oe_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_n;
      rd_q   <= rd_n;
      done_q <= done_n;
      o_q    <= o_n;
      oe_q   <= oe_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
    end
  end

  assign busy      = busy_q;
  assign rd_active = busy_q && rd_q;
  assign bit_idx   = idx_q;
  assign mdio_o    = o_q;
  assign mdio_oe   = oe_q;
  assign done      = done_q;

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !oe_q);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !fall_tick) |=> (busy_q && idx_q == $past(idx_q)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && idx_q >= IDX_W'(ADDR_END)) |-> !oe_q);
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture
  import mdio_pkg::*;
#(
  parameter int LO_IDX = 48,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_tick,
  input  logic              rd_active,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              frame_end,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [DATA_W-1:0] hold_q, hold_n;
  logic              in_data;

  assign in_data = (bit_idx >= IDX_W'(LO_IDX)) && (bit_idx < IDX_W'(LO_IDX + DATA_W));

  always_comb begin
    sh_n   = sh_q;
    hold_n = hold_q;
    if (rise_tick && rd_active && in_data) sh_n = {sh_q[DATA_W-2:0], mdio_i};
    if (frame_end && rd_active)            hold_n = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
    end else begin
      sh_q   <= sh_n;
      hold_q <= hold_n;
    end
  end

  assign rd_data = hold_q;

  assert_hold_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |=> $stable(hold_q));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_sel,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic [15:0] rd_data,
  output logic        done
);
  localparam int IDX_W   = $clog2(PRE_LEN + HDR_W + BODY_W + 2);
  localparam int DATA_LO = PRE_LEN + HDR_W + 2;

  logic             rst_n_s;
  logic             busy, rd_active, frame_end, rise_tick, fall_tick;
  logic [IDX_W-1:0] bit_idx;

  mdio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n_s), .en(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(start), .rd_sel(rd_sel),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .fall_tick(fall_tick), .busy(busy), .rd_active(rd_active),
    .bit_idx(bit_idx), .frame_end(frame_end),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done)
  );

  mdio_capture #(.LO_IDX(DATA_LO), .IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_n_s), .rise_tick(rise_tick), .rd_active(rd_active),
    .bit_idx(bit_idx), .frame_end(frame_end), .mdio_i(mdio_i), .rd_data(rd_data)
  );

  assert_stable_while_high_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  assert_no_change_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(mdc) |-> $stable(mdio_oe));
  assert_done_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(done) |-> ($fell(mdc) && !busy));
endmodule

// File: tb/mdio_frame_engine_test.sv
module mdio_frame_engine_test;
  localparam int DIVH  = 2;
  localparam int PRE   = 32;
  localparam int FRAME = PRE + 32;
  localparam int TOTAL = FRAME + 1;
  localparam int NCYC  = 2 * DIVH * TOTAL + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, rd_sel, mdc, mdio_o, mdio_oe, mdio_i, done;
  logic [4:0]  phy_addr, reg_addr;
  logic [15:0] wr_data, rd_data;
  logic        phy_oe = 1'b0, phy_o = 1'b1;
  logic        line;

  assign line   = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);
  assign mdio_i = line;

  mdio_frame_engine #(.DIV_HALF(DIVH), .PRE_LEN(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .rd_data(rd_data), .done(done)
  );

  int tests = 0, fails = 0;
  int nbits = 0, nfall = 0;
  int contention = 0, err_r7 = 0, err_r2 = 0;
  logic cur_rd = 1'b0;
  logic [15:0] phy_word = '0;
  logic [TOTAL-1:0] rec_line, rec_oe;

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, ~p, p[0] ^ r[4]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Line recorder: what a PHY sees on each rising clock edge
  always @(posedge mdc) begin
    if (nbits < TOTAL) begin
      rec_line[TOTAL-1-nbits] = line;
      rec_oe[TOTAL-1-nbits]   = mdio_oe;
    end
    nbits++;
  end

  // PHY responder: answers read frames after the turnaround
  always @(negedge mdc) begin
    nfall++;
    if (cur_rd && nfall == PRE + 15) begin
      phy_oe <= 1'b1;
      phy_o  <= 1'b0;
    end else if (cur_rd && nfall >= PRE + 16 && nfall < FRAME) begin
      phy_o <= phy_word[FRAME-1-nfall];
    end else if (nfall >= FRAME) begin
      phy_oe <= 1'b0;
      phy_o  <= 1'b1;
    end
  end

  // R7 / R2 monitors
  logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
  int   since_rise = -1;
  always @(negedge clk) begin
    if (mdio_oe && phy_oe) contention++;
    if (mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) err_r7++;
    if (mdc && !prev_mdc) begin
      if (since_rise > 0 && since_rise != 2 * DIVH) err_r2++;
      since_rise = 1;
    end else if (since_rise > 0) begin
      since_rise++;
    end
    if (!uut.busy) since_rise = -1;
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic run_frame(input logic r, input logic [4:0] p, input logic [4:0] a,
                           input logic [15:0] w, input bit poke);
    logic [15:0]      prev_rd;
    logic [TOTAL-1:0] exp_line, exp_oe;
    int               cyc;
    string            dtag;
    @(negedge clk);
    phy_word = phy_val(p, a);
    cur_rd   = r;
    nbits    = 0;
    nfall    = 0;
    prev_rd  = rd_data;
    rd_sel = r; phy_addr = p; reg_addr = a; wr_data = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 1;
    while (!done && cyc < NCYC + 50) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin
        start = 1'b1; rd_sel = ~r; phy_addr = ~p; reg_addr = ~a; wr_data = ~w;
      end else begin
        start = 1'b0;
      end
    end
    exp_line = {{PRE{1'b1}}, 2'b01, r ? 2'b10 : 2'b01, p, a, 2'b10,
                r ? phy_val(p, a) : w, 1'b1};
    for (int k = 0; k < TOTAL; k++)
      exp_oe[TOTAL-1-k] = (k < PRE + 14) || (!r && k < FRAME);
    dtag = r ? "R5 read body" : "R4 write body";
    check(cyc == NCYC, "R2 done latency", 80'(cyc), 80'(NCYC));
    check(nbits == TOTAL, "R2 mdc periods", 80'(nbits), 80'(TOTAL));
    check(rec_line[TOTAL-1 -: PRE+14] == exp_line[TOTAL-1 -: PRE+14], "R3 header bits",
          80'(rec_line[TOTAL-1 -: PRE+14]), 80'(exp_line[TOTAL-1 -: PRE+14]));
    check(rec_line[TOTAL-PRE-15 : 1] == exp_line[TOTAL-PRE-15 : 1], dtag,
          80'(rec_line[TOTAL-PRE-15 : 1]), 80'(exp_line[TOTAL-PRE-15 : 1]));
    check(rec_oe == exp_oe, r ? "R5 line enables" : "R4 line enables",
          80'(rec_oe), 80'(exp_oe));
    check(rec_oe[0] == 1'b0 && rec_line[0] == 1'b1, "R6 idle bit released",
          80'({rec_oe[0], rec_line[0]}), 80'(2'b01));
    check(rd_data == (r ? phy_val(p, a) : prev_rd), r ? "R5 read result" : "R5 write keeps rd_data",
          80'(rd_data), 80'(r ? phy_val(p, a) : prev_rd));
    if (poke) check(cyc == NCYC && rec_line == exp_line, "R8 start ignored while busy",
                    80'(rec_line), 80'(exp_line));
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", 80'(done), 80'(0));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle between frames",
          80'({mdc, mdio_oe}), 80'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_sel = 1'b0;
    phy_addr = '0; reg_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mdc == 0 && mdio_oe == 0 && done == 0 && rd_data == 0, "R1 reset state",
          80'({mdc, mdio_oe, done, rd_data}), 80'(0));
    run_frame(1'b0, 5'h00, 5'h1F, 16'hFFFF, 1'b0);
    check(rd_data == 16'h0, "R5 write before any read", 80'(rd_data), 80'(0));
    for (int i = 0; i < 32; i++) begin
      run_frame(1'b1, 5'(i), 5'(31 - i), 16'h0, i == 7);
      run_frame(1'b0, 5'(31 - i), 5'(i), 16'(i * 16'h0841) ^ 16'hA5C3, i == 9);
    end
    for (int b = 0; b < 16; b++)
      run_frame(1'b0, 5'(b), 5'(b + 3), 16'(1) << b, 1'b0);
    check(contention == 0, "R5 no line contention", 80'(contention), 80'(0));
    check(err_r7 == 0, "R7 outputs stable while mdc high", 80'(err_r7), 80'(0));
    check(err_r2 == 0, "R2 mdc period", 80'(err_r2), 80'(0));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule